// File: doc/BRIEF.md
# Host Byte-Port Memory Window

This block gives a host a narrow view of an internal 32-bit memory through eight byte-wide register offsets. Two offsets hold a 15-bit byte address together with a 2-bit access-mode field. Four offsets, lanes B0 to B3, move data. In long auto-increment mode the host streams whole words. A read of B0 fetches a memory word into a 32-bit holding register, and B1 to B3 then read bytes out of that copy. Writes to B0 to B2 only fill the holding register. A write to B3 stores the full word, and any B3 access steps the address to the next word, so the host can run pass after pass without reloading the address. In byte mode each lane moves one byte at the current word, on lane n, and the address stays where it is.

The host side is a strobed byte port. Read data comes back one cycle after the strobe, marked by a valid pulse. The memory side is a synchronous 32-bit port with byte enables, and its read data is expected one cycle after the request.

Top module: `emi_window`

## Requirements
- R1: After reset the word address, the mode field and the holding register are zero, host_rvalid is low and no memory request is issued.
- R2: Offset 4 is address byte 0: write bits 7:2 set byte-address bits 7:2 and bits 1:0 set the mode; a read returns the same layout. Offset 5 is address byte 1: bits 6:0 are byte-address bits 14:8, and bit 7 is ignored on write and reads as 0. mem_addr carries byte-address bits 14:2.
- R3: A read strobe at offset k yields host_rvalid high in the next cycle only, with the byte for offset k; offsets 6 and 7 read as 0 and ignore writes.
- R4: Mode code 11 is long mode. A long-mode read of B0 (offset 0) issues a memory read at the current word and returns byte 0 of that word. The whole word is kept in the holding register.
- R5: Long-mode reads of B1 to B3 (offsets 1 to 3) return bytes 1 to 3 of the holding register and issue no memory request.
- R6: Long-mode writes to B0 to B2 change only the matching byte of the holding register and issue no memory request.
- R7: A long-mode write to B3 issues a memory write with all four byte enables. The data is the written byte in bits 31:24 over holding-register bytes 2 to 0.
- R8: Any long-mode access to B3, read or write, advances the word address by one, wrapping from 0x1FFF to 0.
- R9: Mode codes 00, 01 and 10 are byte mode: a read of Bn issues a memory read at the current word and returns byte lane n, and the address does not change.
- R10: A byte-mode write of Bn issues a memory write with only enable bit n set and the byte copied to all four lanes. The address and the holding register do not change.
- R11: Writing either address byte clears the holding register to zero.
- R12: When read and write strobes arrive together, only the write takes effect and no read response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_off | input | 3 | Register offset: 0-3 data lanes, 4-5 address bytes |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after the strobe |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | 13 | Word address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, one cycle after a read request |

## Verification
A wrong word address shows on mem_addr at the very next memory request, and on the address-byte reads. A stale or corrupted holding register shows one cycle after the next long-mode B1 to B3 read, or in the data of the next B3 flush. The bench runs a behavioural model and a memory of its own, and compares the memory request signals and the read response in every cycle. A fault therefore shows up in the cycle it reaches a port. Back-to-back sequences check the cycle in which a fetched word is still on its way from memory, where a B0 read is followed at once by a lane read, a partial write or a flush.

// File: rtl/emi_window.sv
module emi_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_off,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_rvalid,
  output logic        mem_en,
  output logic        mem_we,
  output logic [3:0]  mem_be,
  output logic [12:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [1:0] SRC_MEM  = 2'd0;
  localparam logic [1:0] SRC_HOLD = 2'd1;
  localparam logic [1:0] SRC_REG  = 2'd2;

  logic [12:0] waddr;
  logic [1:0]  mode;
  logic [31:0] dreg, dreg_n;
  logic        load_pend;
  logic [1:0]  rsrc_q;
  logic [1:0]  rlane_q;
  logic [7:0]  rbyte_q;

  wire        long_m  = (mode == 2'b11);
  wire        rd      = host_rd & ~host_wr;
  wire        dport   = ~host_off[2];
  wire [1:0]  lane    = host_off[1:0];
  wire        adr_wr  = host_wr & (host_off[2:1] == 2'b10);
  wire        rd_mem  = rd & dport & (~long_m | lane == 2'd0);
  wire        wr_mem  = host_wr & dport & (~long_m | lane == 2'd3);
  wire        advance = long_m & dport & (lane == 2'd3) & (host_wr | rd);
  wire [31:0] deff    = load_pend ? mem_rdata : dreg;

  assign mem_en    = rd_mem | wr_mem;
  assign mem_we    = wr_mem;
  assign mem_be    = long_m ? 4'hF : (4'b0001 << lane);
  assign mem_addr  = waddr;
  assign mem_wdata = long_m ? {host_wdata, deff[23:0]} : {4{host_wdata}};

  always_comb begin
    dreg_n = deff;
    if (adr_wr)
      dreg_n = '0;
    else if (host_wr & dport & long_m)
      dreg_n[{lane, 3'b000} +: 8] = host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr       <= '0;
      mode        <= '0;
      dreg        <= '0;
      load_pend   <= 1'b0;
      host_rvalid <= 1'b0;
      rsrc_q      <= SRC_REG;
      rlane_q     <= '0;
      rbyte_q     <= '0;
    end else begin
      dreg        <= dreg_n;
      load_pend   <= rd & dport & long_m & (lane == 2'd0);
      host_rvalid <= rd;
      if (host_wr && host_off == 3'd4) begin
        waddr[5:0] <= host_wdata[7:2];
        mode       <= host_wdata[1:0];
      end else if (host_wr && host_off == 3'd5) begin
        waddr[12:6] <= host_wdata[6:0];
      end else if (advance) begin
        waddr <= waddr + 13'd1;
      end
      if (rd) begin
        rlane_q <= lane;
        if (dport)
          rsrc_q <= (long_m && lane != 2'd0) ? SRC_HOLD : SRC_MEM;
        else
          rsrc_q <= SRC_REG;
        case (host_off)
          3'd4:    rbyte_q <= {waddr[5:0], mode};
          3'd5:    rbyte_q <= {1'b0, waddr[12:6]};
          default: rbyte_q <= 8'h00;
        endcase
      end
    end
  end

  always_comb begin
    case (rsrc_q)
      SRC_MEM:  host_rdata = mem_rdata[{rlane_q, 3'b000} +: 8];
      SRC_HOLD: host_rdata = deff[{rlane_q, 3'b000} +: 8];
      default:  host_rdata = rbyte_q;
    endcase
  end
endmodule

// File: rtl/emi_window_chk.sv
module emi_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  host_off,
  input logic        host_rd,
  input logic        host_wr,
  input logic        host_rvalid,
  input logic        mem_en,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [12:0] waddr,
  input logic [1:0]  mode,
  input logic [31:0] dreg
);
  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);
  // R12
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> !host_rvalid);
  // R8
  long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !host_off[2] && host_off[1:0] == 2'd3 && (host_rd || host_wr))
    |=> waddr == $past(waddr) + 13'd1);
  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11 && !host_off[2] && (host_rd || host_wr))
    |=> ($stable(waddr) && $stable(mode)));
  // R10
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mode != 2'b11) |-> $countones(mem_be) == 1);
  // R11
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off[2:1] == 2'b10) |=> dreg == 32'd0);
  // R6
  partial_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && host_wr && !host_off[2] && host_off[1:0] != 2'd3) |-> !mem_en);
endmodule

bind emi_window emi_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_rd(host_rd),
  .host_wr(host_wr), .host_rvalid(host_rvalid), .mem_en(mem_en),
  .mem_we(mem_we), .mem_be(mem_be), .waddr(waddr), .mode(mode), .dreg(dreg)
);

// File: tb/emi_window_tb.sv
module emi_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_off = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        mem_en, mem_we;
  logic [3:0]  mem_be;
  logic [12:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  emi_window u_dut (.*);

  logic [31:0] bmem [int];
  logic [31:0] rmem [int];

  function automatic logic [31:0] seed_word(input int a);
    return {a[7:0] ^ 8'hA5, a[12:5], a[7:0] + 8'h3C, ~a[7:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      logic [31:0] t;
      t = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : seed_word(int'(mem_addr));
      if (mem_we) begin
        for (int i = 0; i < 4; i++) if (mem_be[i]) t[i*8 +: 8] = mem_wdata[i*8 +: 8];
        bmem[int'(mem_addr)] = t;
      end else mem_rdata <= t;
    end
  end

  logic [12:0] m_addr = '0;
  logic [1:0]  m_mode = '0;
  logic [31:0] m_hold = '0;
  bit          exp_rv = 0;
  logic [7:0]  exp_rd = '0;
  string       prev_tag = "R1";

  function automatic logic [31:0] rref(input logic [12:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : seed_word(int'(a));
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input string tag, input bit r, input bit w, input logic [2:0] off, input logic [7:0] d);
    bit lng, e_en;
    logic [3:0] e_be;
    logic [31:0] e_wd, t;
    @(negedge clk);
    chk(prev_tag, "rvalid", {31'd0, host_rvalid}, {31'd0, exp_rv});
    if (exp_rv) chk(prev_tag, "rdata", {24'd0, host_rdata}, {24'd0, exp_rd});
    host_rd = r; host_wr = w; host_off = off; host_wdata = d;
    #1;
    lng  = (m_mode == 2'b11);
    e_en = (off < 4) && ((w && (!lng || off == 3)) || (r && !w && (!lng || off == 0)));
    e_be = lng ? 4'hF : (4'b0001 << off[1:0]);
    e_wd = lng ? {d, m_hold[23:0]} : {d, d, d, d};
    chk(tag, "mem_en", {31'd0, mem_en}, {31'd0, e_en});
    if (e_en) begin
      chk(tag, "mem_we", {31'd0, mem_we}, {31'd0, w});
      chk(tag, "mem_addr", {19'd0, mem_addr}, {19'd0, m_addr});
      if (w) begin
        chk(tag, "mem_be", {28'd0, mem_be}, {28'd0, e_be});
        chk(tag, "mem_wdata", mem_wdata, e_wd);
      end
    end
    exp_rv = 0;
    if (w) begin
      if (off < 4) begin
        if (lng) begin
          m_hold[off[1:0]*8 +: 8] = d;
          if (off == 3) begin
            rmem[int'(m_addr)] = m_hold;
            m_addr = m_addr + 1;
          end
        end else begin
          t = rref(m_addr);
          t[off[1:0]*8 +: 8] = d;
          rmem[int'(m_addr)] = t;
        end
      end else if (off == 4) begin
        m_addr[5:0] = d[7:2]; m_mode = d[1:0]; m_hold = '0;
      end else if (off == 5) begin
        m_addr[12:6] = d[6:0]; m_hold = '0;
      end
    end else if (r) begin
      exp_rv = 1;
      if (off < 4) begin
        if (lng) begin
          if (off == 0) m_hold = rref(m_addr);
          exp_rd = m_hold[off[1:0]*8 +: 8];
          if (off == 3) m_addr = m_addr + 1;
        end else exp_rd = rref(m_addr) >> (off[1:0]*8);
      end else if (off == 4) exp_rd = {m_addr[5:0], m_mode};
      else if (off == 5) exp_rd = {1'b0, m_addr[12:6]};
      else exp_rd = 8'h00;
    end
    prev_tag = tag;
  endtask

  task automatic rd_(input string tag, input logic [2:0] off); acc(tag, 1, 0, off, 8'h00); endtask
  task automatic wr_(input string tag, input logic [2:0] off, input logic [7:0] d); acc(tag, 0, 1, off, d); endtask
  task automatic idle(input string tag); acc(tag, 0, 0, 3'd0, 8'h00); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1", "rvalid", {31'd0, host_rvalid}, 32'd0);
    chk("R1", "mem_en", {31'd0, mem_en}, 32'd0);
    rst_n = 1'b1;
    rd_("R1", 3'd4); rd_("R1", 3'd5); rd_("R5", 3'd2); idle("R1");
    // R2 address layout, long mode
    wr_("R2", 3'd5, 8'h92); wr_("R2", 3'd4, {6'h0D, 2'b11});
    rd_("R2", 3'd4); rd_("R2", 3'd5);
    // R4 R5 R8 back-to-back long read passes
    rd_("R4", 3'd0); rd_("R5", 3'd1); rd_("R5", 3'd2); rd_("R8", 3'd3);
    rd_("R4", 3'd0); rd_("R5", 3'd1); rd_("R5", 3'd2); rd_("R8", 3'd3);
    rd_("R8", 3'd4);
    // R6 R7 long writes
    wr_("R6", 3'd0, 8'h11); wr_("R6", 3'd1, 8'h22); wr_("R6", 3'd2, 8'h33);
    rd_("R6", 3'd1); wr_("R7", 3'd3, 8'h44); rd_("R8", 3'd4);
    wr_("R11", 3'd4, {6'h0F, 2'b11});
    rd_("R7", 3'd0); rd_("R7", 3'd3);
    // R11 address write clears holding register
    wr_("R6", 3'd1, 8'h5A); wr_("R11", 3'd5, 8'h12); rd_("R11", 3'd1);
    wr_("R11", 3'd4, {6'h01, 2'b11}); wr_("R11", 3'd3, 8'hEE);
    // fetch in flight followed at once by a partial write and a flush
    wr_("R4", 3'd4, {6'h20, 2'b11});
    rd_("R4", 3'd0); wr_("R6", 3'd1, 8'hC3); wr_("R7", 3'd3, 8'h7E);
    wr_("R4", 3'd4, {6'h20, 2'b11}); rd_("R4", 3'd0); rd_("R5", 3'd1); rd_("R5", 3'd3);
    // R9 R10 byte modes 00, 01, 10
    for (int m = 0; m < 3; m++) begin
      wr_("R9", 3'd4, {6'h05, m[1:0]});
      for (int l = 0; l < 4; l++) rd_("R9", l[2:0]);
      wr_("R10", 3'd2, 8'hB0 + m[7:0]); rd_("R10", 3'd2); rd_("R10", 3'd4);
      rd_("R10", 3'd1); idle("R10");
    end
    // R8 wrap
    wr_("R8", 3'd5, 8'hFF); wr_("R8", 3'd4, 8'hFF); rd_("R8", 3'd3);
    rd_("R8", 3'd4); rd_("R8", 3'd5);
    wr_("R8", 3'd4, 8'hFF); wr_("R8", 3'd5, 8'h7F); wr_("R8", 3'd3, 8'h99);
    rd_("R8", 3'd5); rd_("R8", 3'd4);
    // R12 simultaneous strobes
    acc("R12", 1, 1, 3'd1, 8'h6D); idle("R12"); rd_("R12", 3'd1);
    wr_("R12", 3'd4, 8'h03); acc("R12", 1, 1, 3'd3, 8'h4B); rd_("R12", 3'd4);
    // R3 reserved offsets
    wr_("R3", 3'd6, 8'hFF); wr_("R3", 3'd7, 8'hFF);
    rd_("R3", 3'd6); rd_("R3", 3'd7); rd_("R3", 3'd4); rd_("R3", 3'd5);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [2:0] o;
      logic [7:0] d;
      int k;
      o = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      k = $urandom_range(0, 9);
      if (o == 4 && k < 6) d[1:0] = 2'b11;
      acc("R3", k < 5, k >= 4 && k < 8, o, d);
    end
    idle("R3"); idle("R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule